// File: doc/BRIEF.md
# Line Sync and Back-Porch Generator

This block takes a digitized, active-low composite sync stream, already sampled on the system clock, and rebuilds two per-line timing strobes from it. The first is a horizontal sync pulse that starts on each sync leading (falling) edge. It stays a single pulse per line through field blanking, because a leading edge that comes too soon after the last accepted one is treated as a half-line equalizing or serration edge and dropped. The second is an active-low back-porch gate. It opens a short, fixed delay after each sync trailing (rising) edge and is meant to drive an external black-level clamp.

Every width, delay and interval comes from one timing scale, `CYC_PER_US`, given in clock cycles per microsecond. A second parameter picks 625-line or 525-line line timing. Both standards use the same pulse widths; they differ only in the line period that sets the half-line rejection window. Raising `CYC_PER_US` for a given clock stretches every window together, so the line rate the block tracks is inversely proportional to that parameter. Before any edge detection, the input passes through a two-flop synchronizer and a two-sample agreement filter.

Top module: `line_sync_gen`

## Requirements
- R1: While `rst_ni` is low, `hsync_no` and `bkpch_no` are both high, which is inactive, and the half-line interval counter is cleared.
- R2: A `csync_ni` falling edge, held low for at least 2 samples, drives `hsync_no` low 3 clock edges after the first edge that samples the low input, when the discriminator accepts that edge.
- R3: Each horizontal pulse keeps `hsync_no` low for exactly HS_W = 5*CYC_PER_US cycles.
- R4: A filtered falling edge that arrives fewer than HOLD cycles after the last accepted one starts no pulse. HOLD is floor(3*LINE/4), and LINE is floor(128*CYC_PER_US/2) cycles for 625-line timing. An edge at HOLD cycles or more after the last accepted one is accepted. The first edge after reset is always accepted.
- R5: A filtered rising edge of `csync_ni` drives `bkpch_no` low BP_DLY = ceil(0.3*CYC_PER_US) cycles after the edge is detected, which is 3 edges after the first edge that samples the high input.
- R6: Each back-porch gate keeps `bkpch_no` low for exactly BP_W = floor(4.7*CYC_PER_US) cycles.
- R7: A rising edge detected while a gate is pending or open is ignored. The gate does not restart, and a new gate can begin only once the previous one has fully closed.
- R8: A `csync_ni` excursion lasting a single sample changes neither output.
- R9: With 525-line timing selected, LINE becomes floor(127*CYC_PER_US/2), which makes HOLD smaller, while HS_W, BP_DLY and BP_W are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csync_ni | input | 1 | Composite sync sample, active low |
| hsync_no | output | 1 | Regenerated horizontal sync, active low |
| bkpch_no | output | 1 | Back-porch clamp gate, active low |

## Verification
An input change first reaches a synchronizer flop, and its effect shows at the outputs 3 clock edges later. A horizontal pulse therefore appears 4 sample points after the input is driven. A back-porch gate appears a further BP_DLY sample points after that. The bench drives `csync_ni` at falling clock edges and predicts each pulse window from these fixed latencies and from the HS_W, HOLD, BP_DLY and BP_W arithmetic. It compares both outputs of a 625-line instance and a 525-line instance against that prediction at every falling clock edge. A sweep of leading-edge spacings across both HOLD values then pins the acceptance boundary to the exact cycle for each line standard.

// File: rtl/line_sync_pkg.sv
package line_sync_pkg;

  typedef enum logic [1:0] {BP_IDLE, BP_WAIT, BP_GATE} bp_state_e;

  function automatic int unsigned hs_width(int unsigned cpu);
    return 5 * cpu;
  endfunction

  function automatic int unsigned bp_delay(int unsigned cpu);
    int unsigned d;
    d = (3 * cpu + 9) / 10;
    return (d == 0) ? 1 : d;
  endfunction

  function automatic int unsigned bp_width(int unsigned cpu);
    return (47 * cpu) / 10;
  endfunction

  // line period in cycles; 525-line standard is 63.5 us, 625-line is 64 us
  function automatic int unsigned line_len(int unsigned cpu, bit use_525);
    return ((use_525 ? 127 : 128) * cpu) / 2;
  endfunction

  function automatic int unsigned hold_len(int unsigned cpu, bit use_525);
    return (3 * line_len(cpu, use_525)) / 4;
  endfunction

endpackage

// File: rtl/csync_cond.sv
module csync_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csync_ni,
  output logic fall_o,
  output logic rise_o
);
  logic [2:0] sh_q;
  logic       lvl_q;
  logic       lvl_d;

  // new level only once two consecutive synced samples agree
  always_comb lvl_d = (sh_q[1] == sh_q[2]) ? sh_q[1] : lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '1;
      lvl_q <= 1'b1;
    end else begin
      sh_q  <= {sh_q[1:0], csync_ni};
      lvl_q <= lvl_d;
    end
  end

  assign fall_o = lvl_q & ~lvl_d;
  assign rise_o = ~lvl_q & lvl_d;
endmodule

// File: rtl/line_hs_disc.sv
module line_hs_disc #(
  parameter int unsigned HS_W = 50,
  parameter int unsigned HOLD = 480
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  output logic hs_on_o
);
  localparam int unsigned GW = $clog2(HOLD + 1);
  localparam int unsigned PW = $clog2(HS_W + 1);

  logic          armed_q;
  logic [GW-1:0] gap_q;
  logic          hs_on_q;
  logic [PW-1:0] hs_cnt_q;
  logic          accept;

  assign accept = fall_i & armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b1;
      gap_q    <= '0;
      hs_on_q  <= 1'b0;
      hs_cnt_q <= '0;
    end else if (accept) begin
      armed_q  <= 1'b0;
      gap_q    <= '0;
      hs_on_q  <= 1'b1;
      hs_cnt_q <= PW'(HS_W - 1);
    end else begin
      if (!armed_q) begin
        gap_q <= gap_q + 1'b1;
        // arm so an edge exactly HOLD cycles after the last one is taken
        if (gap_q == GW'(HOLD - 2)) armed_q <= 1'b1;
      end
      if (hs_on_q) begin
        if (hs_cnt_q == '0) hs_on_q <= 1'b0;
        else                hs_cnt_q <= hs_cnt_q - 1'b1;
      end
    end
  end

  assign hs_on_o = hs_on_q;
endmodule

// File: rtl/bp_gate.sv
module bp_gate
  import line_sync_pkg::*;
#(
  parameter int unsigned DLY = 3,
  parameter int unsigned WID = 47
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  output logic gate_o
);
  localparam int unsigned MAXC = (DLY > WID) ? DLY : WID;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  bp_state_e     st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BP_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        BP_IDLE: if (rise_i) begin
          st_q  <= BP_WAIT;
          cnt_q <= CW'(DLY - 1);
        end
        BP_WAIT: if (cnt_q == '0) begin
          st_q  <= BP_GATE;
          cnt_q <= CW'(WID - 1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        BP_GATE: if (cnt_q == '0) st_q <= BP_IDLE;
                 else             cnt_q <= cnt_q - 1'b1;
        default: st_q <= BP_IDLE;
      endcase
    end
  end

  assign gate_o = (st_q == BP_GATE);
endmodule

// File: rtl/line_sync_gen.sv
module line_sync_gen
  import line_sync_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 10,
  parameter bit          USE_525    = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csync_ni,
  output logic hsync_no,
  output logic bkpch_no
);
  localparam int unsigned HS_W = hs_width(CYC_PER_US);
  localparam int unsigned HOLD = hold_len(CYC_PER_US, USE_525);
  localparam int unsigned BP_D = bp_delay(CYC_PER_US);
  localparam int unsigned BP_W = bp_width(CYC_PER_US);

  logic fall, rise, hs_on, gate;

  csync_cond u_cond (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .csync_ni(csync_ni),
    .fall_o  (fall),
    .rise_o  (rise)
  );

  line_hs_disc #(.HS_W(HS_W), .HOLD(HOLD)) u_hs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fall_i (fall),
    .hs_on_o(hs_on)
  );

  bp_gate #(.DLY(BP_D), .WID(BP_W)) u_bp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rise_i(rise),
    .gate_o(gate)
  );

  assign hsync_no = ~hs_on;
  assign bkpch_no = ~gate;
endmodule

// File: rtl/line_sync_chk.sv
module line_sync_chk
  import line_sync_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 10,
  parameter bit          USE_525    = 1'b0
) (
  input logic clk_i,
  input logic rst_ni,
  input logic csync_ni,
  input logic hsync_no,
  input logic bkpch_no
);
  localparam int unsigned HS_W = hs_width(CYC_PER_US);
  localparam int unsigned HOLD = hold_len(CYC_PER_US, USE_525);
  localparam int unsigned BP_W = bp_width(CYC_PER_US);
  localparam int unsigned HW   = $clog2(HS_W + 2);
  localparam int unsigned GW   = $clog2(HOLD + 2);
  localparam int unsigned BW   = $clog2(BP_W + 2);

  logic [2:0]    since_rst_q;
  logic [HW-1:0] hs_low_q;
  logic [BW-1:0] bp_low_q;
  logic [GW-1:0] gap_q;
  logic          hs_prev_q;
  logic          hs_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst_q <= '0;
      hs_low_q    <= '0;
      bp_low_q    <= '0;
      gap_q       <= '0;
      hs_prev_q   <= 1'b1;
      hs_seen_q   <= 1'b0;
    end else begin
      if (since_rst_q != 3'd7) since_rst_q <= since_rst_q + 1'b1;
      hs_low_q  <= hsync_no ? '0 : hs_low_q + 1'b1;
      bp_low_q  <= bkpch_no ? '0 : bp_low_q + 1'b1;
      hs_prev_q <= hsync_no;
      if (hs_prev_q && !hsync_no) begin
        gap_q     <= GW'(1);
        hs_seen_q <= 1'b1;
      end else if (gap_q < GW'(HOLD)) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  always @(posedge clk_i)
    if (!rst_ni) AST_RST_IDLE: assert (hsync_no && bkpch_no) else $error("outputs active in reset"); // R1

  AST_HS_FROM_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hsync_no) && since_rst_q > 3'd4) |-> !$past(csync_ni, 4)); // R2

  AST_HS_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_no && hs_low_q != '0) |-> hs_low_q == HW'(HS_W)); // R3

  AST_HS_HOLDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hsync_no) |-> (!hs_seen_q || gap_q >= GW'(HOLD))); // R4

  AST_BP_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bkpch_no && bp_low_q != '0) |-> bp_low_q == BW'(BP_W)); // R6
endmodule

bind line_sync_gen line_sync_chk #(.CYC_PER_US(CYC_PER_US), .USE_525(USE_525)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .csync_ni(csync_ni),
  .hsync_no(hsync_no),
  .bkpch_no(bkpch_no)
);

// File: tb/line_sync_gen_test.sv
`timescale 1ns/1ps
module line_sync_gen_test;
  localparam int CPU    = 10;
  localparam int HS_W   = 5 * CPU;
  localparam int HOLD_A = (3 * ((128 * CPU) / 2)) / 4;
  localparam int HOLD_B = (3 * ((127 * CPU) / 2)) / 4;
  localparam int DLY    = (3 * CPU + 9) / 10;
  localparam int BPW    = (47 * CPU) / 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csync = 1'b1;
  logic hs_a, bp_a, hs_b, bp_b;

  always #2.5 clk = ~clk;

  line_sync_gen #(.CYC_PER_US(CPU), .USE_525(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .csync_ni(csync), .hsync_no(hs_a), .bkpch_no(bp_a));

  line_sync_gen #(.CYC_PER_US(CPU), .USE_525(1'b1)) uut_b (
    .clk_i(clk), .rst_ni(rst_n), .csync_ni(csync), .hsync_no(hs_b), .bkpch_no(bp_b));

  int cyc = 0, checks = 0, errors = 0;
  logic lvl = 1'b1;
  int last_a = -100000, last_b = -100000, bp_start = -100000, bp_end = -100000;
  string hs_tag = "R1", hsb_tag = "R1", bp_tag = "R1";
  bit done = 1'b0;

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cyc=%0d act=%b exp=%b", tag, what, cyc, act, exp);
    end
  endtask

  task automatic step();
    logic ea, eb, ep;
    @(negedge clk);
    cyc++;
    ea = !(cyc >= last_a && cyc < last_a + HS_W);
    eb = !(cyc >= last_b && cyc < last_b + HS_W);
    ep = !(cyc >= bp_start && cyc < bp_start + BPW);
    chk(hs_tag,  "hsync_625", hs_a, ea);
    chk(hsb_tag, "hsync_525", hs_b, eb);
    chk(bp_tag,  "bkpch_625", bp_a, ep);
    chk(bp_tag,  "bkpch_525", bp_b, ep);
  endtask

  // drive a level for len samples; detected edge is visible 4 sample points later
  task automatic seg(logic v, int len);
    csync = v;
    if (len >= 2 && v != lvl) begin
      int d;
      d = cyc + 4;
      lvl = v;
      if (!v) begin
        if (d - last_a >= HOLD_A) last_a = d;
        if (d - last_b >= HOLD_B) last_b = d;
      end else if (d > bp_end) begin
        bp_start = d + DLY;
        bp_end   = d + DLY + BPW;
      end
    end
    repeat (len) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all act=timeout exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: both outputs idle during reset
    repeat (4) begin
      @(negedge clk);
      chk("R1", "hsync_625", hs_a, 1'b1);
      chk("R1", "bkpch_625", bp_a, 1'b1);
      chk("R1", "hsync_525", hs_b, 1'b1);
      chk("R1", "bkpch_525", bp_b, 1'b1);
    end
    rst_n = 1'b1;
    seg(1'b1, 20);

    // R2 / R5: first line, latency of both pulses
    hs_tag = "R2"; hsb_tag = "R2"; bp_tag = "R5";
    seg(1'b0, 47); seg(1'b1, 593);

    // R3 / R6: steady lines
    hs_tag = "R3"; hsb_tag = "R3"; bp_tag = "R6";
    repeat (3) begin seg(1'b0, 47); seg(1'b1, 593); end

    // R4: half-line equalizing pulses, one hsync per full line
    hs_tag = "R4"; hsb_tag = "R4";
    repeat (8) begin seg(1'b0, 23); seg(1'b1, 297); end
    seg(1'b1, 700);

    // R4 / R9: spacing sweep across both holdoff values
    hsb_tag = "R9";
    for (int s = 470; s <= 486; s++) begin
      seg(1'b0, 5); seg(1'b1, s - 5);
      seg(1'b0, 5); seg(1'b1, 700);
    end

    // R8: single-sample glitches
    hs_tag = "R8"; hsb_tag = "R8"; bp_tag = "R8";
    repeat (6) begin seg(1'b0, 1); seg(1'b1, 6); end
    seg(1'b1, 600);

    // R7: second trailing edge while gate pending is ignored
    hs_tag = "R4"; hsb_tag = "R4"; bp_tag = "R7";
    seg(1'b0, 5); seg(1'b1, 3); seg(1'b0, 5); seg(1'b1, 600);
    seg(1'b0, 5); seg(1'b1, 30); seg(1'b0, 5); seg(1'b1, 600);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule